// File: doc/BRIEF.md
# Processor Clock-Cycle Counter Unit

This unit keeps the cycle accounting for one core that runs two hardware threads. It holds three kinds of counter:

- A 64-bit time-stamp counter that follows the bus clock and the sleep controls.
- One non-halted counter for each thread.
- One non-sleep counter shared by the whole core.

Every clock, the unit looks at the status inputs and decides which counters advance. The status inputs are the halt flag of each thread, the sleep pin, a two-bit sleep depth and a bus-clock-active qualifier.

Software reaches the counters through a small register port. In the same cycle it raises a valid strobe, gives an address and a write-enable, and for a write supplies the data. A read answers on the next cycle. A write takes effect at the next clock edge.

A control register holds three things: the time-stamp write mode, which is legacy or full; one interrupt enable for each per-thread counter; and one interrupt enable for the core counter. A sticky overflow register records counter wraps, and the interrupt output follows the enabled flags.

Top module: `cyc_acct_unit`

## Requirements

Register map:

| Address | Register |
|---|---|
| 0 | Time-stamp counter |
| 1 | Thread 0 non-halted counter |
| 2 | Thread 1 non-halted counter |
| 3 | Non-sleep counter |
| 4 | Control |
| 5 | Overflow flags |

Control register fields:

| Bit | Meaning |
|---|---|
| 0 | Full write mode (1 = full, 0 = legacy) |
| 1 | Interrupt enable for thread 0 |
| 2 | Interrupt enable for thread 1 |
| 3 | Interrupt enable for the non-sleep counter |

Overflow register fields:

| Bit | Source |
|---|---|
| 0 | Thread 0 counter |
| 1 | Thread 1 counter |
| 2 | Non-sleep counter |

Sleep depth values: 0 is awake, 1 and 2 are light sleep levels, 3 is deep sleep.

- R1: A synchronous reset clears all counters, the overflow flags and the control register. This leaves legacy write mode selected and the interrupt output low.
- R2: A read request returns `rsp_valid` high and the full 64-bit register value on the cycle after the request. The value is the one the register held when the request was sampled. Registers narrower than 64 bits read back zero-extended.
- R3: The time-stamp counter advances by one only on cycles where `bus_clk_act` is high and `sleep_pin` is low.
- R4: A sleep depth of 3 stops the time-stamp counter. Sleep depths 1 and 2, and halted threads, do not stop it.
- R5: The non-halted counter of thread i advances only when `thr_halt[i]` is low, `sleep_pin` is low and the sleep depth is 0.
- R6: The 40-bit non-sleep counter advances when `sleep_pin` is low and the sleep depth is 0. The one exception is when both threads are halted together: then it holds. One halted thread alone does not stop it.
- R7: In legacy mode (control bit 0 = 0), a write to address 0 loads bits 31:0 of the write data into the time-stamp counter and clears its upper 32 bits.
- R8: In full mode (control bit 0 = 1), a write to address 0 loads all 64 bits. Writes to the 40-bit counters keep the low 40 bits of the data.
- R9: When a write to a counter and an increment of that counter fall on the same cycle, the written value is loaded and that cycle's increment is lost.
- R10: A 40-bit counter that advances from all ones wraps to zero and sets its sticky overflow flag. Writing 1 to a bit of address 5 clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R11: `irq` is high exactly while some overflow flag is set and its enable bit in the control register is also set.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_clk_act | input | 1 | Bus clock active qualifier |
| sleep_pin | input | 1 | Sleep pin, high when asserted |
| sleep_lvl | input | 2 | Sleep depth (0 awake, 3 deep) |
| thr_halt | input | 2 | Halt state of each thread |
| req_valid | input | 1 | Register request strobe |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| irq | output | 1 | Overflow interrupt |

## Verification

The counters are run under several status patterns:

- Halt on one thread only, then on neither thread, then on both. This separates per-thread gating from per-core gating. In particular it shows that one halted thread leaves the shared counter running.
- Bus clock off, the sleep pin on, and each sleep depth in turn. This separates the time-stamp condition from the condition used by the performance counters. Depths 1 and 2 stop the performance counters but not the time-stamp counter.

Writes are applied twice in each mode: once while the counters are frozen, which isolates the legacy and full masking, and once while they run, which exposes the write-over-increment priority. Counters are preloaded near all ones so that a wrap can be reached within a few cycles. This shows when a flag is set, and that a flag which is set but not enabled keeps the interrupt low.

// File: rtl/cyc_acct_unit.sv
module cyc_acct_unit #(
  parameter int CW       = 40,
  parameter int TW       = 64,
  parameter int DEEP_LVL = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_clk_act,
  input  logic          sleep_pin,
  input  logic [1:0]    sleep_lvl,
  input  logic [1:0]    thr_halt,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [2:0]    req_addr,
  input  logic [63:0]   req_wdata,
  output logic          rsp_valid,
  output logic [63:0]   rsp_rdata,
  output logic          irq
);
  localparam int NTHR = 2;
  localparam int HW   = TW / 2;
  localparam logic [2:0] A_TSC = 3'd0, A_NH0 = 3'd1, A_NH1 = 3'd2,
                         A_NS  = 3'd3, A_CTL = 3'd4, A_OVF = 3'd5;

  logic [TW-1:0] tsc_q;
  logic [CW-1:0] nh_q [NTHR];
  logic [CW-1:0] ns_q;
  logic [3:0]    ctl_q;
  logic [2:0]    ovf_q;

  wire core_asleep = sleep_pin | (sleep_lvl != 2'd0);
  wire tsc_tick    = bus_clk_act & ~sleep_pin & (sleep_lvl != 2'(DEEP_LVL));
  wire ns_tick     = ~core_asleep & ~(&thr_halt);
  wire wr          = req_valid & req_we;
  wire wr_tsc      = wr & (req_addr == A_TSC);
  wire wr_ns       = wr & (req_addr == A_NS);
  wire wr_ctl      = wr & (req_addr == A_CTL);
  wire wr_ovf      = wr & (req_addr == A_OVF);

  logic [NTHR-1:0] nh_tick, wr_nh, nh_wrap;
  always_comb
    for (int i = 0; i < NTHR; i++) begin
      nh_tick[i] = ~core_asleep & ~thr_halt[i];
      wr_nh[i]   = wr & (req_addr == 3'(i + 1));
      nh_wrap[i] = nh_tick[i] & ~wr_nh[i] & (&nh_q[i]);
    end

  wire       ns_wrap = ns_tick & ~wr_ns & (&ns_q);
  wire [2:0] ovf_clr = wr_ovf ? req_wdata[2:0] : 3'b000;

  always_ff @(posedge clk)
    if (rst) begin
      tsc_q <= '0;
      ns_q  <= '0;
      ctl_q <= '0;
      ovf_q <= '0;
      for (int i = 0; i < NTHR; i++) nh_q[i] <= '0;
    end else begin
      if (wr_tsc)
        tsc_q <= ctl_q[0] ? req_wdata[TW-1:0] : {{HW{1'b0}}, req_wdata[HW-1:0]};
      else if (tsc_tick)
        tsc_q <= tsc_q + 1'b1;
      for (int i = 0; i < NTHR; i++)
        if (wr_nh[i])        nh_q[i] <= req_wdata[CW-1:0];
        else if (nh_tick[i]) nh_q[i] <= nh_q[i] + 1'b1;
      if (wr_ns)        ns_q <= req_wdata[CW-1:0];
      else if (ns_tick) ns_q <= ns_q + 1'b1;
      if (wr_ctl) ctl_q <= req_wdata[3:0];
      ovf_q <= (ovf_q & ~ovf_clr) | {ns_wrap, nh_wrap};
    end

  logic [63:0] rd_mux;
  always_comb
    case (req_addr)
      A_TSC:   rd_mux = 64'(tsc_q);
      A_NH0:   rd_mux = 64'(nh_q[0]);
      A_NH1:   rd_mux = 64'(nh_q[1]);
      A_NS:    rd_mux = 64'(ns_q);
      A_CTL:   rd_mux = 64'(ctl_q);
      A_OVF:   rd_mux = 64'(ovf_q);
      default: rd_mux = '0;
    endcase

  always_ff @(posedge clk)
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid & ~req_we;
      if (req_valid & ~req_we) rsp_rdata <= rd_mux;
    end

  assign irq = |(ovf_q & ctl_q[3:1]);
endmodule

module cyc_acct_chk #(
  parameter int CW       = 40,
  parameter int TW       = 64,
  parameter int DEEP_LVL = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep_pin,
  input logic [1:0]    sleep_lvl,
  input logic [1:0]    thr_halt,
  input logic          req_valid,
  input logic          req_we,
  input logic [2:0]    req_addr,
  input logic          rsp_valid,
  input logic [TW-1:0] tsc,
  input logic [CW-1:0] ns,
  input logic [3:0]    ctl,
  input logic [2:0]    ovf
);
  wire wr_tsc = req_valid & req_we & (req_addr == 3'd0);
  wire wr_ns  = req_valid & req_we & (req_addr == 3'd3);

  // R4
  deep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_lvl == 2'(DEEP_LVL) && !wr_tsc) |=> $stable(tsc));

  // R6
  both_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (&thr_halt && !wr_ns) |=> $stable(ns));

  // R6
  one_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep_pin && sleep_lvl == 2'd0 && $countones(thr_halt) == 1 && !wr_ns)
      |=> ns == CW'($past(ns) + 1'b1));

  // R7
  legacy_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_tsc && !ctl[0]) |=> tsc[TW-1:TW/2] == '0);

  // R2
  rsp_src_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_we));

  // R10
  ns_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf[2]) |-> $past(&ns));
endmodule

bind cyc_acct_unit cyc_acct_chk #(.CW(CW), .TW(TW), .DEEP_LVL(DEEP_LVL)) u_chk (
  .clk(clk), .rst(rst), .sleep_pin(sleep_pin), .sleep_lvl(sleep_lvl),
  .thr_halt(thr_halt), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .tsc(tsc_q), .ns(ns_q),
  .ctl(ctl_q), .ovf(ovf_q)
);

// File: tb/sim_cyc_acct_unit.sv
`timescale 1ns/1ps
module sim_cyc_acct_unit;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_clk_act, sleep_pin;
  logic [1:0] sleep_lvl, thr_halt;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [2:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, irq;
  logic [63:0] rsp_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [63:0] M40 = 64'hFF_FFFF_FFFF;

  always #2 clk = ~clk;

  cyc_acct_unit u0 (.*);

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic quiet();
    bus_clk_act = 1'b0; sleep_pin = 1'b1; sleep_lvl = 2'd0; thr_halt = 2'b11;
  endtask

  task automatic run(logic b, logic p, logic [1:0] l, logic [1:0] h, int n);
    @(negedge clk);
    bus_clk_act = b; sleep_pin = p; sleep_lvl = l; thr_halt = h;
    repeat (n) @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  task automatic wr(logic [2:0] a, logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(posedge clk);
    #1;
    d = rsp_rdata;
    check("R2 rsp_valid", 64'(rsp_valid), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic clear_cnt();
    for (int a = 0; a < 4; a++) wr(3'(a), 64'd0);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reset value", d, 64'd0);
    end
    check("R1 irq low", 64'(irq), 64'd0);
  endtask

  task automatic t_tsc_gate();
    logic [63:0] d;
    clear_cnt();
    run(1, 0, 2'd0, 2'b00, 5);
    rd(3'd0, d); check("R3 tsc runs", d, 64'd5);
    run(0, 0, 2'd0, 2'b00, 4);
    run(1, 1, 2'd0, 2'b00, 4);
    rd(3'd0, d); check("R3 tsc gated by bus/pin", d, 64'd5);
    run(1, 0, 2'd1, 2'b11, 3);
    run(1, 0, 2'd2, 2'b01, 2);
    rd(3'd0, d); check("R4 light sleep and halt keep tsc", d, 64'd10);
    run(1, 0, 2'd3, 2'b00, 6);
    rd(3'd0, d); check("R4 deep sleep stops tsc", d, 64'd10);
  endtask

  task automatic t_perf_gate();
    logic [63:0] d;
    clear_cnt();
    run(1, 0, 2'd0, 2'b01, 4);
    run(1, 0, 2'd0, 2'b00, 3);
    run(0, 1, 2'd0, 2'b00, 5);
    run(1, 0, 2'd1, 2'b00, 2);
    run(1, 0, 2'd2, 2'b00, 2);
    rd(3'd1, d); check("R5 thread0 non-halted", d, 64'd3);
    rd(3'd2, d); check("R5 thread1 non-halted", d, 64'd7);
    rd(3'd3, d); check("R6 non-sleep single halt", d, 64'd7);
    run(1, 0, 2'd0, 2'b11, 5);
    rd(3'd3, d); check("R6 both halted gate", d, 64'd7);
    rd(3'd2, d); check("R5 thread1 halted holds", d, 64'd7);
  endtask

  task automatic t_wr_mode();
    logic [63:0] d;
    wr(3'd0, 64'hDEAD_BEEF_1234_5678);
    rd(3'd0, d); check("R7 legacy tsc write", d, 64'h0000_0000_1234_5678);
    wr(3'd4, 64'd1);
    wr(3'd0, 64'hDEAD_BEEF_1234_5678);
    rd(3'd0, d); check("R8 full tsc write", d, 64'hDEAD_BEEF_1234_5678);
    wr(3'd1, 64'hABCD_0123_4567_89AB);
    rd(3'd1, d); check("R8 counter write truncated", d, 64'h23_4567_89AB);
    wr(3'd4, 64'd0);
  endtask

  task automatic t_wr_prio();
    logic [63:0] d;
    clear_cnt();
    @(negedge clk);
    bus_clk_act = 1; sleep_pin = 0; sleep_lvl = 0; thr_halt = 2'b00;
    req_valid = 1; req_we = 1; req_addr = 3'd3; req_wdata = 64'd100;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_we = 0;
    quiet();
    rd(3'd3, d); check("R9 write wins over increment", d, 64'd100);
    rd(3'd1, d); check("R9 other counter still counts", d, 64'd1);
  endtask

  task automatic t_overflow();
    logic [63:0] d;
    wr(3'd5, 64'd7);
    wr(3'd4, 64'b0010);
    wr(3'd1, M40 - 1);
    wr(3'd3, M40);
    run(1, 0, 2'd0, 2'b10, 1);
    rd(3'd5, d); check("R10 non-sleep wrap flag", d, 64'd4);
    rd(3'd3, d); check("R10 non-sleep wrapped", d, 64'd0);
    check("R11 flag not enabled", 64'(irq), 64'd0);
    run(1, 0, 2'd0, 2'b10, 1);
    rd(3'd5, d); check("R10 thread0 wrap flag", d, 64'd5);
    rd(3'd1, d); check("R10 thread0 wrapped", d, 64'd0);
    check("R11 irq raised", 64'(irq), 64'd1);
    run(1, 0, 2'd0, 2'b10, 3);
    rd(3'd5, d); check("R10 flags sticky", d, 64'd5);
    wr(3'd5, 64'd1);
    rd(3'd5, d); check("R10 write one clears", d, 64'd4);
    check("R11 irq dropped", 64'(irq), 64'd0);
    wr(3'd4, 64'b1000);
    check("R11 enable pending flag", 64'(irq), 64'd1);
    wr(3'd5, 64'd4);
    check("R11 irq after clear", 64'(irq), 64'd0);
  endtask

  initial begin
    quiet();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_tsc_gate();
    t_perf_gate();
    t_wr_mode();
    t_wr_prio();
    t_overflow();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule